// File: doc/BRIEF.md
# Multi-Target SPI Master with Per-Target Clock Settings

This block is a single-master SPI controller for a bus with several targets, each reached through its own active-low select line. A small settings table holds, for every target, a clock polarity, a clock phase and a clock divider. When a transfer to a target begins, the master copies that target's entry into its working settings. Switching between targets with different modes therefore needs no extra software step.

Data moves in both directions at once. Each accepted command byte is shifted out on `mosi`, most significant bit first, and the byte shifted in from `miso` over the same eight clocks is returned on `rx_data`. A command carries one byte plus a "last" flag. Clearing the flag keeps the target selected and the master waits for the next byte of the burst. The bus has no acknowledgement and no flow control, so the master cannot tell whether a target is present.

Top module: `spi_multi_target_master`

## Requirements
- R1: A write on the settings port (`cfg_we` high) stores polarity, phase and divider for target `cfg_tgt`. A later transfer to that target runs with a half SCLK period of exactly divider+1 clock cycles.
- R2: The first byte of a burst selects target `cmd_tgt`. Only line `cs_n[cmd_tgt]` goes low, and at most one select line is ever low.
- R3: While no target is selected, `sclk` rests at the polarity level (0 = low, 1 = high) of the most recently selected target. A new polarity is applied one half period before the select line falls, and `sclk` is back at that level when the select line rises.
- R4: With phase 0, `mosi` carries bit 7 of the byte at the moment select falls. `miso` is sampled on leading edges (away from the rest level) and `mosi` changes on trailing edges. With phase 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R5: Each byte is sent MSB first using exactly 16 SCLK edges, and the target receives the byte that was given on `cmd_data`.
- R6: After the last edge of every byte, `rx_valid` pulses high for one cycle. `rx_data` then holds the eight `miso` samples of that byte, first sample in bit 7.
- R7: A byte with `cmd_last` = 0 leaves the select line low after its 16 edges. `cmd_ready` is high only when idle or when waiting between the bytes of a burst, and it is low in the cycle after a byte is accepted. With `cmd_last` = 1 the select line rises one half period after the final edge.
- R8: `cmd_tgt` on the second and later bytes of a burst is ignored, and the same select line stays low for the whole burst.
- R9: A settings write made during a burst does not change that burst. The new settings apply from the next burst to that target.
- R10: After reset all select lines are high, `sclk` is low, `cmd_ready` is high, `rx_valid` is low, and every table entry holds polarity 0, phase 0 and divider 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings table write strobe |
| cfg_tgt | input | TGT_W | Table entry to write |
| cfg_cpol | input | 1 | Clock polarity to store |
| cfg_cpha | input | 1 | Clock phase to store |
| cfg_div | input | DIV_W | Divider to store (half period = value+1 cycles) |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_tgt | input | TGT_W | Target for a new burst |
| cmd_data | input | DATA_W | Byte to transmit |
| cmd_last | input | 1 | Final byte of the burst |
| rx_valid | output | 1 | One-cycle strobe, received byte available |
| rx_data | output | DATA_W | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to targets |
| miso | input | 1 | Serial data from the selected target |
| cs_n | output | NUM_TGT | Active-low select, one line per target |

## Verification
The bench builds the block with four targets, a 4-bit divider and 8-bit bytes. This lets one sweep program all four targets with four different polarity/phase pairs and run each at divider values 0, 1 and 3. A behavioural target on the bench side follows the snapshot of its settings taken when select falls. It checks every received bit and edge interval against those settings and supplies reply bytes computed from a byte counter. With four targets, bursts that jump between targets of opposite polarity are easy to stage, as are the ignored-target and mid-burst settings-write cases.

// File: rtl/spi_tc_pkg.sv
// Shared types for the multi-target SPI master.
// Assumes nothing beyond standard SystemVerilog packages.
package spi_tc_pkg;

    // Sequencer phases of one burst.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_HOLD,
        ST_TAIL
    } tc_state_e;

endpackage

// File: rtl/spi_tc_cfg_table.sv
// Per-target settings storage: polarity, phase and divider for each target.
// One write port and one combinational read port.
// Assumes rd_idx and wr_idx are below NUM_TGT.
module spi_tc_cfg_table #(
    parameter int NUM_TGT = 4,
    parameter int DIV_W   = 8,
    parameter int TGT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TGT_W-1:0] wr_idx,
    input  logic             wr_cpol,
    input  logic             wr_cpha,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [TGT_W-1:0] rd_idx,
    output logic             rd_cpol,
    output logic             rd_cpha,
    output logic [DIV_W-1:0] rd_div
);

    logic             cpol_q [NUM_TGT];
    logic             cpha_q [NUM_TGT];
    logic [DIV_W-1:0] div_q  [NUM_TGT];

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_entry
        // Hold one target's settings; reset to mode 0 with the fastest divider.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cpol_q[g] <= 1'b0;
                cpha_q[g] <= 1'b0;
                div_q[g]  <= '0;
            end else if (wr_en && (wr_idx == TGT_W'(g))) begin
                cpol_q[g] <= wr_cpol;
                cpha_q[g] <= wr_cpha;
                div_q[g]  <= wr_div;
            end
        end
    end

    // Read the entry of the requested target.
    always_comb begin
        rd_cpol = cpol_q[rd_idx];
        rd_cpha = cpha_q[rd_idx];
        rd_div  = div_q[rd_idx];
    end

endmodule

// File: rtl/spi_tc_timer.sv
// Half-period timer: after a load of value V it flags expiry V+1 cycles later.
// Assumes the caller reloads it on each expiry it acts on.
module spi_tc_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             expired
);

    logic [DIV_W-1:0] cnt_q;

    // Count down from the loaded divider and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_tc_shift.sv
// Shift/sample engine for one byte: counts 2*DATA_W clock edges and launches
// or samples on leading/trailing edges depending on the phase.
// Assumes load and step never occur in the same cycle.
module spi_tc_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_cpha,
    input  logic              run_cpha,
    input  logic              step,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte,
    output logic              last_edge
);

    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_E = EDGE_W'(EDGES - 1);

    logic [EDGE_W-1:0] ecnt_q;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] rx_q;
    logic              mosi_q;
    logic              lead;
    logic              sample_now;

    assign lead       = ~ecnt_q[0];
    assign sample_now = (lead == ~run_cpha);
    assign last_edge  = (ecnt_q == LAST_E);

    // Load a new byte, then launch or capture one bit per clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt_q <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            ecnt_q <= '0;
            if (!load_cpha) begin
                mosi_q <= load_data[DATA_W-1];
                sh_q   <= {load_data[DATA_W-2:0], 1'b0};
            end else begin
                sh_q   <= load_data;
            end
        end else if (step) begin
            ecnt_q <= last_edge ? '0 : ecnt_q + 1'b1;
            if (sample_now) begin
                rx_q <= {rx_q[DATA_W-2:0], miso};
            end else if (!last_edge) begin
                mosi_q <= sh_q[DATA_W-1];
                sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign mosi    = mosi_q;
    assign rx_byte = rx_q;

    AST_NO_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)); // R5

endmodule

// File: rtl/spi_multi_target_master.sv
// Multi-target SPI master. Each burst latches the selected target's table
// entry, places SCLK at its rest level, asserts the select line, and runs
// 16 edges per byte. The select line stays low until a byte flagged last.
// Assumes miso is already synchronous to clk.
module spi_multi_target_master
    import spi_tc_pkg::*;
#(
    parameter int NUM_TGT = 4,
    parameter int DIV_W   = 8,
    parameter int DATA_W  = 8,
    parameter int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [TGT_W-1:0]   cfg_tgt,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [TGT_W-1:0]   cmd_tgt,
    input  logic [DATA_W-1:0]  cmd_data,
    input  logic               cmd_last,
    output logic               rx_valid,
    output logic [DATA_W-1:0]  rx_data,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_TGT-1:0] cs_n
);

    localparam logic [NUM_TGT-1:0] ONE_SEL = NUM_TGT'(1);

    tc_state_e          state_q;
    logic [TGT_W-1:0]   act_tgt_q;
    logic               act_cpol_q;
    logic               act_cpha_q;
    logic [DIV_W-1:0]   act_div_q;
    logic               act_last_q;
    logic               sclk_q;
    logic [NUM_TGT-1:0] cs_n_q;
    logic               rx_valid_q;

    logic               tbl_cpol;
    logic               tbl_cpha;
    logic [DIV_W-1:0]   tbl_div;
    logic               accept;
    logic               tmr_load;
    logic [DIV_W-1:0]   tmr_val;
    logic               tmr_exp;
    logic               step;
    logic               last_edge;
    logic               load_cpha;

    spi_tc_cfg_table #(
        .NUM_TGT (NUM_TGT),
        .DIV_W   (DIV_W),
        .TGT_W   (TGT_W)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_tgt),
        .wr_cpol (cfg_cpol),
        .wr_cpha (cfg_cpha),
        .wr_div  (cfg_div),
        .rd_idx  (cmd_tgt),
        .rd_cpol (tbl_cpol),
        .rd_cpha (tbl_cpha),
        .rd_div  (tbl_div)
    );

    spi_tc_timer #(
        .DIV_W (DIV_W)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    spi_tc_shift #(
        .DATA_W (DATA_W)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (cmd_data),
        .load_cpha (load_cpha),
        .run_cpha  (act_cpha_q),
        .step      (step),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_data),
        .last_edge (last_edge)
    );

    // Handshake and control strobes derived from the current phase.
    always_comb begin
        cmd_ready = (state_q == ST_IDLE) || (state_q == ST_HOLD);
        accept    = cmd_valid && cmd_ready;
        step      = (state_q == ST_XFER) && tmr_exp;
        load_cpha = (state_q == ST_IDLE) ? tbl_cpha : act_cpha_q;
        tmr_val   = (state_q == ST_IDLE) ? tbl_div  : act_div_q;
        tmr_load  = accept
                 || ((state_q == ST_SETUP) && tmr_exp)
                 || (step && (!last_edge || act_last_q));
    end

    // Burst sequencer: latch settings, select, clock bytes, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            act_tgt_q  <= '0;
            act_cpol_q <= 1'b0;
            act_cpha_q <= 1'b0;
            act_div_q  <= '0;
            act_last_q <= 1'b0;
            sclk_q     <= 1'b0;
            cs_n_q     <= '1;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= step && last_edge;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        act_tgt_q  <= cmd_tgt;
                        act_cpol_q <= tbl_cpol;
                        act_cpha_q <= tbl_cpha;
                        act_div_q  <= tbl_div;
                        act_last_q <= cmd_last;
                        sclk_q     <= tbl_cpol;
                        state_q    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tmr_exp) begin
                        cs_n_q  <= ~(ONE_SEL << act_tgt_q);
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (step) begin
                        sclk_q <= ~sclk_q;
                        if (last_edge) begin
                            state_q <= act_last_q ? ST_TAIL : ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (accept) begin
                        act_last_q <= cmd_last;
                        state_q    <= ST_XFER;
                    end
                end
                ST_TAIL: begin
                    if (tmr_exp) begin
                        cs_n_q  <= '1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk     = sclk_q;
    assign cs_n     = cs_n_q;
    assign rx_valid = rx_valid_q;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_q) <= 1); // R2

    AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sclk_q == act_cpol_q)); // R3

    AST_SCLK_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cs_n_q) && $past(&cs_n_q) && (state_q != ST_SETUP)) |-> $stable(sclk_q)); // R3

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_q |=> !rx_valid_q); // R6

    AST_SELECT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER) && $past(state_q == ST_XFER)) |-> $stable(cs_n_q)); // R8

endmodule

// File: tb/spi_multi_target_master_tb_top.sv
// Self-checking bench: a behavioural target model follows the settings
// snapshot taken at select fall and checks bits, edges and intervals.
module spi_multi_target_master_tb_top;

    localparam int NT = 4;
    localparam int DW = 4;
    localparam int BW = 8;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [TW-1:0] cfg_tgt = '0;
    logic          cfg_cpol = 1'b0;
    logic          cfg_cpha = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [TW-1:0] cmd_tgt = '0;
    logic [BW-1:0] cmd_data = '0;
    logic          cmd_last = 1'b0;
    logic          rx_valid;
    logic [BW-1:0] rx_data;
    logic          sclk;
    logic          mosi;
    logic          miso = 1'b0;
    logic [NT-1:0] cs_n;

    always #4 clk = ~clk;

    spi_multi_target_master #(
        .NUM_TGT (NT),
        .DIV_W   (DW),
        .DATA_W  (BW),
        .TGT_W   (TW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_tgt   (cfg_tgt),
        .cfg_cpol  (cfg_cpol),
        .cfg_cpha  (cfg_cpha),
        .cfg_div   (cfg_div),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_tgt   (cmd_tgt),
        .cmd_data  (cmd_data),
        .cmd_last  (cmd_last),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    // Bench copy of the settings table and of everything sent.
    logic          t_cpol [NT];
    logic          t_cpha [NT];
    int            t_div  [NT];
    logic [BW-1:0] sent   [256];
    int            tx_count = 0;
    int            exp_tgt  = 0;

    // Target model state.
    logic          sl_cpol, sl_cpha;
    int            sl_div;
    int            sl_idx = 0;
    int            ns = 0;
    logic [BW-1:0] rbuf;
    int            edges = 0;
    int            cyc = 0;
    int            base = 0;
    bit            sel_bad = 0;
    logic [NT-1:0] sel_vec;
    logic          sclk_prev = 1'b0;
    bit            sel_prev = 0;
    int            rx_idx = 0;
    bit            rxv_prev = 0;

    function automatic logic [BW-1:0] reply_of(int j);
        return BW'((j * 29 + 90) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(int t, bit cpol, bit cpha, int div);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tgt = TW'(t); cfg_cpol = cpol; cfg_cpha = cpha; cfg_div = DW'(div);
        @(negedge clk);
        cfg_we = 1'b0;
        t_cpol[t] = cpol; t_cpha[t] = cpha; t_div[t] = div;
    endtask

    task automatic send_byte(int t, logic [BW-1:0] d, bit last, bit first);
        if (first) exp_tgt = t;
        sent[tx_count] = d;
        tx_count++;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_tgt = TW'(t); cmd_data = d; cmd_last = last;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, "R7", "ready low after accept", int'(cmd_ready), 0);
    endtask

    task automatic wait_done();
        while (sl_idx < tx_count) @(negedge clk);
        while (cs_n != '1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Behavioural target and bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        bit sel_now;
        bit lead;
        int tg;
        if (rst_n) begin
            sel_now = (cs_n != '1);
            cyc++;
            if (sel_now && !sel_prev) begin
                tg = 0;
                for (int i = 0; i < NT; i++) if (!cs_n[i]) tg = i;
                chk(($countones(~cs_n) == 1) && (tg == exp_tgt), "R2", "selected line", tg, exp_tgt);
                sl_cpol = t_cpol[tg]; sl_cpha = t_cpha[tg]; sl_div = t_div[tg];
                chk(sclk == sl_cpol, "R3", "sclk rest level at select", int'(sclk), int'(sl_cpol));
                if (!sl_cpha) begin
                    chk(mosi == sent[sl_idx][BW-1], "R4", "first bit at select", int'(mosi), int'(sent[sl_idx][BW-1]));
                    miso = reply_of(sl_idx)[BW-1];
                end
                ns = 0; rbuf = '0; edges = 0; cyc = 0; sel_bad = 0; sel_vec = cs_n;
            end else if (sel_now && sel_prev) begin
                if (cs_n != sel_vec) sel_bad = 1;
                if (sclk != sclk_prev) begin
                    if ((edges == 0) || (edges % 16 != 0))
                        chk(cyc == sl_div + 1, "R1", "half period", cyc, sl_div + 1);
                    cyc = 0;
                    edges++;
                    lead = (sclk != sl_cpol);
                    if (!sl_cpha) begin
                        if (lead) begin
                            rbuf = {rbuf[BW-2:0], mosi}; ns++;
                        end else begin
                            if (ns == BW) begin
                                chk(rbuf == sent[sl_idx], "R4", "byte at target (phase 0)", int'(rbuf), int'(sent[sl_idx]));
                                sl_idx++; ns = 0;
                            end
                            miso = reply_of(sl_idx)[BW-1-ns];
                        end
                    end else begin
                        if (lead) begin
                            miso = reply_of(sl_idx)[BW-1-ns];
                        end else begin
                            rbuf = {rbuf[BW-2:0], mosi}; ns++;
                            if (ns == BW) begin
                                chk(rbuf == sent[sl_idx], "R5", "byte at target (phase 1)", int'(rbuf), int'(sent[sl_idx]));
                                sl_idx++; ns = 0;
                            end
                        end
                    end
                end
            end else if (!sel_now && sel_prev) begin
                chk(edges == 16 * (tx_count - base), "R5", "edges per burst", edges, 16 * (tx_count - base));
                chk(!sel_bad, "R8", "select steady during burst", int'(sel_bad), 0);
                chk(sclk == sl_cpol, "R3", "sclk level at release", int'(sclk), int'(sl_cpol));
                base = tx_count;
            end
            if (rx_valid) begin
                chk(rx_data == reply_of(rx_idx), "R6", "received byte", int'(rx_data), int'(reply_of(rx_idx)));
                chk(!rxv_prev, "R6", "rx_valid single cycle", int'(rxv_prev), 0);
                rx_idx++;
            end
            rxv_prev  = rx_valid;
            sel_prev  = sel_now;
            sclk_prev = sclk;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin
            t_cpol[i] = 1'b0; t_cpha[i] = 1'b0; t_div[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state at the ports.
        chk(cs_n == '1, "R10", "selects after reset", int'(cs_n), 15);
        chk(sclk == 1'b0, "R10", "sclk after reset", int'(sclk), 0);
        chk(cmd_ready == 1'b1, "R10", "ready after reset", int'(cmd_ready), 1);
        chk(rx_valid == 1'b0, "R10", "rx_valid after reset", int'(rx_valid), 0);

        // R10: an unwritten entry runs mode 0 at divider 0.
        send_byte(3, 8'h96, 1'b1, 1'b1);
        wait_done();

        // R1..R7: sweep modes and dividers over all targets with 3-byte bursts.
        foreach (t_div[k]) begin end
        for (int d = 0; d < 3; d++) begin
            for (int m = 0; m < 4; m++) begin
                int dv;
                dv = (d == 0) ? 0 : ((d == 1) ? 1 : 3);
                cfg_write(m, m[1], m[0], dv);
                for (int b = 0; b < 3; b++)
                    send_byte(m, BW'((tx_count * 53 + 17) & 255), b == 2, b == 0);
                wait_done();
                send_byte(m, BW'(~(tx_count * 11)), 1'b1, 1'b1);
                wait_done();
            end
        end

        // R8: target field on a continuation byte is ignored.
        send_byte(1, 8'h3C, 1'b0, 1'b1);
        send_byte(2, 8'hC3, 1'b1, 1'b0);
        wait_done();

        // R9: settings write during a burst leaves that burst unchanged.
        cfg_write(2, 1'b0, 1'b1, 1);
        send_byte(2, 8'h5A, 1'b0, 1'b1);
        while (cs_n == '1) @(negedge clk);
        cfg_write(2, 1'b1, 1'b0, 2);
        send_byte(2, 8'hA5, 1'b1, 1'b0);
        wait_done();
        send_byte(2, 8'h0F, 1'b1, 1'b1);
        wait_done();
        chk(sl_idx == tx_count, "R9", "all bytes reached the target", sl_idx, tx_count);
        chk(rx_idx == tx_count, "R6", "one rx strobe per byte", rx_idx, tx_count);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule